// File: doc/BRIEF.md
# Receive Frame Rule Classifier

This block sorts received Ethernet frames into pass or drop as their bytes stream in. It holds a table of rules. Each rule looks at one 32-bit word of the frame, picked by a word offset, and compares it with stored data. The compare uses a per-bit enable mask, so only the enabled bits count. A rule with a terminal flag ends its group: the pass flag accepts the frame and the drop flag rejects it. A rule with neither flag is chained: it must hit together with the rules that follow it, up to and including the next terminal rule.

Software fills the table through a one-cycle write strobe. Frames arrive one byte per valid beat, with start and end markers. In the cycle after the end beat, the block gives one verdict: pass or drop, plus the receive DMA channel to use. A byte match that does not fall on a word boundary is split across two chained rules at consecutive word offsets. The first rule holds the shifted upper part of the mask and the second holds the lower part.

Top module: `frame_rule_classifier`

## Requirements
- R1: After reset, every rule below the top index has a zero mask and no flags, so it acts as a chained, always-hitting rule. The top rule has a zero mask, the pass flag, the end flag and channel 0. Before any frame, `vd_vld` is low.
- R2: Frame byte k is held in word k/4, at bits 8*(k%4)+7 down to 8*(k%4). A rule hits when ((word XOR data) AND mask) is zero.
- R3: A rule with a nonzero mask misses unless all four bytes of its word arrived before the frame ended. A rule with a zero mask hits for any frame length.
- R4: A rule with neither `cfg_pass` nor `cfg_drop` set is chained. Its group decides only when every rule in the group hits.
- R5: Groups are tried in rising index order. The first group that hits decides the verdict.
- R6: A deciding rule with only the pass flag set gives `vd_pass`=1. If its drop flag is set, with or without the pass flag, it gives `vd_pass`=0. In both cases `vd_chan` is the rule's channel.
- R7: No rule above the first rule with the end flag takes part. If no group decides, the verdict is drop on channel 0.
- R8: `vd_vld` is high for exactly the one cycle after each end-of-frame beat of an open frame, and at no other time.
- R9: A table write is ignored on the start beat of a frame, on every beat inside the frame, and on the end beat.
- R10: A 4-byte match at a byte offset with remainder r is split into two chained rules. The first, at the word offset, has mask and data shifted left by 8*r. The second, at the word offset plus 1, has them shifted right by 32-8*r. The pair passes only when both parts hit.
- R11: Only the first MAX_BYTE_OFF+4 bytes of a frame are held. A rule whose word offset lies beyond that window never hits. A valid byte outside a frame is ignored, and a start beat inside a frame restarts the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | IDX_W | Index of the rule to write |
| cfg_data | input | 32 | Compare data |
| cfg_mask | input | 32 | Per-bit compare enable |
| cfg_woff | input | OFF_W | Word offset into the frame |
| cfg_pass | input | 1 | Pass flag (terminal) |
| cfg_drop | input | 1 | Drop flag (terminal) |
| cfg_end | input | 1 | Marks the last rule that takes part |
| cfg_chan | input | CH_W | DMA channel reported on a decision |
| rx_vld | input | 1 | Byte beat valid |
| rx_byte | input | 8 | Frame byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| vd_vld | output | 1 | One-cycle verdict strobe |
| vd_pass | output | 1 | 1 means pass, 0 means drop |
| vd_chan | output | CH_W | Channel of the deciding rule |

## Verification
The assertions expect frames to be well formed. A beat with `rx_eof` closes the frame, and only a beat with `rx_sof` opens one. A table write lands only when no frame is open and no start beat is present. The stimulus keeps every table write outside frames, except in the one scenario that drives writes on purpose on a start beat and on a middle beat. It also sends single-byte frames back to back, so the one-cycle verdict strobe is covered on consecutive cycles.

// File: rtl/frc_pkg.sv
// Shared widths and the masked-word compare used by the rule classifier.
package frc_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned WORD_BYTES = WORD_W / BYTE_W;

    typedef logic [WORD_W-1:0] word_t;

    // True when every enabled bit of the word agrees with the data.
    function automatic logic word_hit(input word_t w, input word_t d, input word_t m);
        return ((w ^ d) & m) == '0;
    endfunction
endpackage

// File: rtl/frc_rule_table.sv
// Rule storage. Each rule has data, mask, word offset, pass/drop/end flags and
// a channel. Reset leaves chained always-hit rules, plus a catch-all pass rule
// at the top index. Assumes wr_blocked is high for every beat of an open frame.
module frc_rule_table
    import frc_pkg::*;
#(
    parameter int unsigned N     = 64,
    parameter int unsigned IDX_W = 6,
    parameter int unsigned OFF_W = 5,
    parameter int unsigned CH_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_blocked,
    input  logic [IDX_W-1:0] wr_idx,
    input  word_t            wr_data,
    input  word_t            wr_mask,
    input  logic [OFF_W-1:0] wr_off,
    input  logic             wr_pass,
    input  logic             wr_drop,
    input  logic             wr_end,
    input  logic [CH_W-1:0]  wr_chan,
    output word_t            r_data [N],
    output word_t            r_mask [N],
    output logic [OFF_W-1:0] r_off  [N],
    output logic [N-1:0]     r_pass,
    output logic [N-1:0]     r_drop,
    output logic [N-1:0]     r_end,
    output logic [CH_W-1:0]  r_chan [N]
);
    logic wr_go;
    assign wr_go = wr_en && !wr_blocked;

    for (genvar i = 0; i < N; i++) begin : g_rule
        localparam logic IS_TOP = (i == N - 1);
        // Hold one rule; reset to chained always-hit or to the catch-all.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r_data[i] <= '0;
                r_mask[i] <= '0;
                r_off[i]  <= '0;
                r_pass[i] <= IS_TOP;
                r_drop[i] <= 1'b0;
                r_end[i]  <= IS_TOP;
                r_chan[i] <= '0;
            end else if (wr_go && wr_idx == IDX_W'(i)) begin
                r_data[i] <= wr_data;
                r_mask[i] <= wr_mask;
                r_off[i]  <= wr_off;
                r_pass[i] <= wr_pass;
                r_drop[i] <= wr_drop;
                r_end[i]  <= wr_end;
                r_chan[i] <= wr_chan;
            end
        end
    end

    AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_blocked) |=> (r_data[$past(wr_idx)] == $past(r_data[wr_idx])
            && r_mask[$past(wr_idx)] == $past(r_mask[wr_idx])
            && r_chan[$past(wr_idx)] == $past(r_chan[wr_idx]))); // R9
endmodule

// File: rtl/frc_capture.sv
// Byte-stream capture. Tracks whether a frame is open, packs frame bytes into
// a little-endian word window (byte k at word k/4) and counts the bytes held.
// Shows the window and count including the current beat, so a compare made on
// the end beat sees the final byte. Bytes past the window are dropped.
module frc_capture
    import frc_pkg::*;
#(
    parameter int unsigned NWORDS = 17,
    parameter int unsigned CNT_W  = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_vld,
    input  logic [BYTE_W-1:0]        in_byte,
    input  logic                     in_sof,
    input  logic                     in_eof,
    output logic                     busy_o,
    output logic                     eval_o,
    output logic [NWORDS*WORD_W-1:0] win_nxt,
    output logic [CNT_W-1:0]         cnt_nxt
);
    localparam int unsigned NBYTES = NWORDS * WORD_BYTES;

    logic                     open_q;
    logic [NWORDS*WORD_W-1:0] win_q;
    logic [CNT_W-1:0]         cnt_q;
    logic                     start, take;
    logic [CNT_W-1:0]         pos;

    assign start  = in_vld && in_sof;
    assign take   = in_vld && (open_q || in_sof);
    assign busy_o = open_q || start;
    assign eval_o = take && in_eof;
    assign pos    = start ? '0 : cnt_q;

    // Place the current byte in the window and advance the count.
    always_comb begin
        win_nxt = win_q;
        cnt_nxt = pos;
        for (int b = 0; b < NBYTES; b++) begin
            if (take && pos == CNT_W'(b)) begin
                win_nxt[b*BYTE_W +: BYTE_W] = in_byte;
                cnt_nxt = CNT_W'(b + 1);
            end
        end
    end

    // Track whether a frame is open and keep the window between beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            win_q  <= '0;
            cnt_q  <= '0;
        end else begin
            if (take) open_q <= !in_eof;
            win_q <= win_nxt;
            cnt_q <= cnt_nxt;
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(NBYTES)); // R11
    AST_EOF_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_eof) |=> !open_q); // R8
endmodule

// File: rtl/frc_match.sv
// Compares every rule at once with the captured window. Chains the hits of
// non-terminal rules into their group and picks the first deciding group in
// index order, stopping after the first rule with the end flag. Pure
// combinational logic; clk and rst_n only clock the assertions.
module frc_match
    import frc_pkg::*;
#(
    parameter int unsigned N      = 64,
    parameter int unsigned NWORDS = 17,
    parameter int unsigned OFF_W  = 5,
    parameter int unsigned CH_W   = 4,
    parameter int unsigned CNT_W  = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NWORDS*WORD_W-1:0] win,
    input  logic [CNT_W-1:0]         cnt,
    input  word_t                    r_data [N],
    input  word_t                    r_mask [N],
    input  logic [OFF_W-1:0]         r_off  [N],
    input  logic [N-1:0]             r_pass,
    input  logic [N-1:0]             r_drop,
    input  logic [N-1:0]             r_end,
    input  logic [CH_W-1:0]          r_chan [N],
    output logic                     pass_o,
    output logic [CH_W-1:0]          chan_o
);
    logic [N-1:0] hit, term, run, sel;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        word_t w;
        logic  avail;

        // Select the window word this rule points at.
        always_comb begin
            w = '0;
            for (int k = 0; k < NWORDS; k++)
                if (r_off[i] == OFF_W'(k)) w = win[k*WORD_W +: WORD_W];
        end

        assign avail = (int'(r_off[i]) < NWORDS) &&
                       (int'(cnt) >= WORD_BYTES * (int'(r_off[i]) + 1));
        assign hit[i]  = (r_mask[i] == '0) || (avail && word_hit(w, r_data[i], r_mask[i]));
        assign term[i] = r_pass[i] || r_drop[i];

        if (i == 0) begin : g_head
            assign run[i] = hit[i];
        end else begin : g_link
            assign run[i] = hit[i] && (term[i-1] || run[i-1]);
        end
    end

    // First-winner search in index order; the end flag closes the search.
    always_comb begin
        logic done;
        done   = 1'b0;
        sel    = '0;
        pass_o = 1'b0;
        chan_o = '0;
        for (int i = 0; i < N; i++) begin
            if (!done) begin
                if (term[i] && run[i]) begin
                    sel[i] = 1'b1;
                    pass_o = r_pass[i] && !r_drop[i];
                    chan_o = r_chan[i];
                    done   = 1'b1;
                end
                if (r_end[i]) done = 1'b1;
            end
        end
    end

    AST_WINNER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel & ~(run & term)) == '0); // R5
    AST_DROP_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |-> (!pass_o && chan_o == '0)); // R7
endmodule

// File: rtl/frame_rule_classifier.sv
// Top of the receive frame rule classifier. Ties together rule storage,
// byte capture and the parallel match, and registers one verdict per frame.
// Assumes frames are opened by a start beat and closed by an end beat.
module frame_rule_classifier
    import frc_pkg::*;
#(
    parameter int unsigned NUM_RULES    = 64,
    parameter int unsigned MAX_BYTE_OFF = 64,
    parameter int unsigned CH_W         = 4,
    localparam int unsigned IDX_W  = $clog2(NUM_RULES),
    localparam int unsigned NWORDS = MAX_BYTE_OFF / WORD_BYTES + 1,
    localparam int unsigned OFF_W  = $clog2(NWORDS),
    localparam int unsigned CNT_W  = $clog2(NWORDS * WORD_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [31:0]      cfg_data,
    input  logic [31:0]      cfg_mask,
    input  logic [OFF_W-1:0] cfg_woff,
    input  logic             cfg_pass,
    input  logic             cfg_drop,
    input  logic             cfg_end,
    input  logic [CH_W-1:0]  cfg_chan,
    input  logic             rx_vld,
    input  logic [7:0]       rx_byte,
    input  logic             rx_sof,
    input  logic             rx_eof,
    output logic             vd_vld,
    output logic             vd_pass,
    output logic [CH_W-1:0]  vd_chan
);
    word_t                    r_data [NUM_RULES];
    word_t                    r_mask [NUM_RULES];
    logic [OFF_W-1:0]         r_off  [NUM_RULES];
    logic [CH_W-1:0]          r_chan [NUM_RULES];
    logic [NUM_RULES-1:0]     r_pass, r_drop, r_end;
    logic                     busy, eval;
    logic [NWORDS*WORD_W-1:0] win;
    logic [CNT_W-1:0]         cnt;
    logic                     m_pass;
    logic [CH_W-1:0]          m_chan;

    frc_rule_table #(.N(NUM_RULES), .IDX_W(IDX_W), .OFF_W(OFF_W), .CH_W(CH_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_blocked(busy), .wr_idx(cfg_idx),
        .wr_data(cfg_data), .wr_mask(cfg_mask), .wr_off(cfg_woff),
        .wr_pass(cfg_pass), .wr_drop(cfg_drop), .wr_end(cfg_end), .wr_chan(cfg_chan),
        .r_data(r_data), .r_mask(r_mask), .r_off(r_off),
        .r_pass(r_pass), .r_drop(r_drop), .r_end(r_end), .r_chan(r_chan)
    );

    frc_capture #(.NWORDS(NWORDS), .CNT_W(CNT_W)) u_capture (
        .clk(clk), .rst_n(rst_n),
        .in_vld(rx_vld), .in_byte(rx_byte), .in_sof(rx_sof), .in_eof(rx_eof),
        .busy_o(busy), .eval_o(eval), .win_nxt(win), .cnt_nxt(cnt)
    );

    frc_match #(.N(NUM_RULES), .NWORDS(NWORDS), .OFF_W(OFF_W), .CH_W(CH_W), .CNT_W(CNT_W)) u_match (
        .clk(clk), .rst_n(rst_n), .win(win), .cnt(cnt),
        .r_data(r_data), .r_mask(r_mask), .r_off(r_off),
        .r_pass(r_pass), .r_drop(r_drop), .r_end(r_end), .r_chan(r_chan),
        .pass_o(m_pass), .chan_o(m_chan)
    );

    // Register the verdict on the end beat; the strobe lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vd_vld  <= 1'b0;
            vd_pass <= 1'b0;
            vd_chan <= '0;
        end else begin
            vd_vld <= eval;
            if (eval) begin
                vd_pass <= m_pass;
                vd_chan <= m_chan;
            end
        end
    end

    AST_VERDICT_FOLLOWS_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld && rx_eof && busy) |=> vd_vld); // R8
    AST_VERDICT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        vd_vld |-> $past(rx_vld && rx_eof)); // R8
endmodule

// File: tb/frame_rule_classifier_bench.sv
module frame_rule_classifier_bench;
    localparam int N = 64;
    localparam int NW = 17;
    localparam int NB = NW * 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 0, cfg_pass = 0, cfg_drop = 0, cfg_end = 0;
    logic [5:0] cfg_idx = '0;
    logic [31:0] cfg_data = '0, cfg_mask = '0;
    logic [4:0] cfg_woff = '0;
    logic [3:0] cfg_chan = '0;
    logic rx_vld = 0, rx_sof = 0, rx_eof = 0;
    logic [7:0] rx_byte = '0;
    logic vd_vld, vd_pass;
    logic [3:0] vd_chan;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [7:0] fb [0:127];

    always #5 clk = ~clk;

    frame_rule_classifier u_frame_rule_classifier (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_data(cfg_data), .cfg_mask(cfg_mask), .cfg_woff(cfg_woff),
        .cfg_pass(cfg_pass), .cfg_drop(cfg_drop), .cfg_end(cfg_end), .cfg_chan(cfg_chan),
        .rx_vld(rx_vld), .rx_byte(rx_byte), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .vd_vld(vd_vld), .vd_pass(vd_pass), .vd_chan(vd_chan)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_data [N];
    logic [31:0] m_mask [N];
    int          m_off  [N];
    bit          m_pass [N];
    bit          m_drop [N];
    bit          m_end  [N];
    int          m_chan [N];
    logic [7:0]  fq [$];
    bit m_open = 0;
    bit e_vld = 0, e_pass = 0;
    int e_chan = 0;

    function automatic bit m_hit(int i);
        logic [31:0] w;
        int o;
        if (m_mask[i] == 0) return 1;
        o = m_off[i];
        if (o >= NW || fq.size() < 4 * (o + 1)) return 0;
        w = {fq[4*o+3], fq[4*o+2], fq[4*o+1], fq[4*o]};
        return ((w ^ m_data[i]) & m_mask[i]) == 0;
    endfunction

    task automatic m_eval(output bit p, output int c);
        bit grp;
        grp = 1; p = 0; c = 0;
        for (int i = 0; i < N; i++) begin
            grp = grp && m_hit(i);
            if (m_pass[i] || m_drop[i]) begin
                if (grp) begin
                    p = m_pass[i] && !m_drop[i];
                    c = m_chan[i];
                    return;
                end
                grp = 1;
            end
            if (m_end[i]) return;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_data[i] = 0; m_mask[i] = 0; m_off[i] = 0; m_drop[i] = 0; m_chan[i] = 0;
                m_pass[i] = (i == N - 1); m_end[i] = (i == N - 1);
            end
            fq.delete(); m_open = 0; e_vld = 0; e_pass = 0; e_chan = 0;
        end else begin
            bit busy, p;
            int c;
            busy = m_open || (rx_vld && rx_sof);
            e_vld = 0;
            if (cfg_we && !busy) begin
                m_data[cfg_idx] = cfg_data; m_mask[cfg_idx] = cfg_mask;
                m_off[cfg_idx] = cfg_woff; m_pass[cfg_idx] = cfg_pass;
                m_drop[cfg_idx] = cfg_drop; m_end[cfg_idx] = cfg_end;
                m_chan[cfg_idx] = cfg_chan;
            end
            if (rx_vld) begin
                if (rx_sof) begin fq.delete(); m_open = 1; end
                if (m_open) begin
                    if (fq.size() < NB) fq.push_back(rx_byte);
                    if (rx_eof) begin
                        m_eval(p, c);
                        e_vld = 1; e_pass = p; e_chan = c;
                        m_open = 0;
                    end
                end
            end
        end
    end

    // Cycle-by-cycle comparison with the model (R8 strobe, R5 content).
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            n_chk++;
            if (vd_vld !== e_vld) begin
                n_fail++;
                $display("FAIL R8 model: vd_vld=%0b expected %0b at %0t", vd_vld, e_vld, $time);
            end else if (e_vld && (vd_pass !== e_pass || vd_chan !== 4'(e_chan))) begin
                n_fail++;
                $display("FAIL R5 model: pass/chan=%0b/%0d expected %0b/%0d at %0t",
                         vd_pass, vd_chan, e_pass, e_chan, $time);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wr(input int idx, input logic [31:0] d, input logic [31:0] m, input int off,
                      input bit p, input bit dr, input bit e, input int ch);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 6'(idx); cfg_data = d; cfg_mask = m; cfg_woff = 5'(off);
        cfg_pass = p; cfg_drop = dr; cfg_end = e; cfg_chan = 4'(ch);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic send(input int len, input bit xp, input int xc, input string tag);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_vld = 1; rx_byte = fb[i]; rx_sof = (i == 0); rx_eof = (i == len - 1);
        end
        @(negedge clk);
        rx_vld = 0; rx_sof = 0; rx_eof = 0;
        check(vd_vld === 1'b1, {tag, " strobe"}, int'(vd_vld), 1);
        check(vd_pass === xp && vd_chan === 4'(xc), tag, {vd_pass, vd_chan}, {xp, 4'(xc)});
        @(negedge clk);
        check(vd_vld === 1'b0, "R8 one-cycle strobe", int'(vd_vld), 0);
    endtask

    task automatic fill(input logic [7:0] base);
        for (int i = 0; i < 128; i++) fb[i] = base + 8'(i);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    initial begin
        do_reset();
        // R1: reset state, catch-all passes on channel 0
        @(negedge clk);
        check(vd_vld === 1'b0, "R1 idle strobe", int'(vd_vld), 0);
        fill(8'h00);
        send(8, 1, 0, "R1 catch-all");

        // R2: full-word and partial-mask compares
        wr(0, 32'hDDCCBBAA, 32'hFFFFFFFF, 1, 1, 0, 0, 5);
        wr(1, 32'h0, 32'h0, 0, 0, 1, 0, 2);
        fb[0]=8'h00; fb[1]=8'h11; fb[2]=8'h22; fb[3]=8'h33;
        fb[4]=8'hAA; fb[5]=8'hBB; fb[6]=8'hCC; fb[7]=8'hDD;
        send(8, 1, 5, "R2 word hit");
        fb[6] = 8'hCD;
        send(8, 0, 2, "R2 word miss");
        wr(0, 32'h0000BB00, 32'h0000FF00, 1, 1, 0, 0, 5);
        fb[4] = 8'hEE; fb[7] = 8'h99;
        send(8, 1, 5, "R2 partial mask");
        // R3: short frame misses; zero mask hits a one-byte frame
        send(6, 0, 2, "R3 word incomplete");
        send(1, 0, 2, "R3 zero mask one byte");

        // R4: chained pair
        do_reset();
        wr(0, 32'h000000A1, 32'h000000FF, 0, 0, 0, 0, 0);
        wr(1, 32'h000000B2, 32'h000000FF, 1, 1, 0, 0, 7);
        wr(2, 32'h0, 32'h0, 0, 0, 1, 0, 2);
        fill(8'h00); fb[0] = 8'hA1; fb[4] = 8'hB2;
        send(8, 1, 7, "R4 chain both hit");
        fb[0] = 8'hA0;
        send(8, 0, 2, "R4 chain first miss");

        // R5 and R6: priority and flag meaning
        do_reset();
        wr(0, 32'h00000055, 32'h000000FF, 0, 0, 1, 0, 3);
        wr(1, 32'h0, 32'h0, 0, 1, 0, 0, 6);
        fill(8'h00); fb[0] = 8'h55;
        send(4, 0, 3, "R5 first group wins");
        fb[0] = 8'h56;
        send(4, 1, 6, "R6 pass with channel");
        wr(1, 32'h0, 32'h0, 0, 1, 1, 0, 6);
        send(4, 0, 6, "R6 pass and drop gives drop");

        // R7: end flag stops the search
        do_reset();
        wr(0, 32'h0000005A, 32'h000000FF, 0, 1, 0, 1, 4);
        fill(8'h00);
        send(4, 0, 0, "R7 no decision drop ch0");
        fb[0] = 8'h5A;
        send(4, 1, 4, "R7 last rule hit");

        // R10: split match at byte offset 6 (r=2)
        do_reset();
        wr(0, 32'h22110000, 32'hFFFF0000, 1, 0, 0, 0, 0);
        wr(1, 32'h00004433, 32'h0000FFFF, 2, 1, 0, 0, 9);
        wr(2, 32'h0, 32'h0, 0, 0, 1, 0, 1);
        fill(8'h80); fb[6]=8'h11; fb[7]=8'h22; fb[8]=8'h33; fb[9]=8'h44;
        send(12, 1, 9, "R10 split hit");
        fb[9] = 8'h45;
        send(12, 0, 1, "R10 split second miss");
        fb[9] = 8'h44; fb[6] = 8'h10;
        send(12, 0, 1, "R10 split first miss");

        // R9: writes on the start beat and mid-frame are ignored
        do_reset();
        wr(0, 32'h0000005A, 32'h000000FF, 0, 1, 0, 0, 4);
        wr(1, 32'h0, 32'h0, 0, 0, 1, 0, 2);
        fill(8'h00); fb[0] = 8'h5A;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rx_vld = 1; rx_byte = fb[i]; rx_sof = (i == 0); rx_eof = (i == 5);
            cfg_we = (i == 0 || i == 3); cfg_idx = 0; cfg_mask = 0;
            cfg_pass = 0; cfg_drop = 1; cfg_end = 0; cfg_chan = 7;
        end
        @(negedge clk);
        rx_vld = 0; rx_sof = 0; rx_eof = 0; cfg_we = 0;
        check(vd_vld === 1'b1 && vd_pass === 1'b1 && vd_chan === 4'd4, "R9 frame with writes",
              {vd_vld, vd_pass, vd_chan}, {1'b1, 1'b1, 4'd4});
        send(6, 1, 4, "R9 table unchanged");

        // R11: window edge, stray byte, restart
        do_reset();
        wr(0, 32'h00000000, 32'h000000FF, 17, 1, 0, 0, 8);
        wr(1, 32'h43424140, 32'hFFFFFFFF, 16, 1, 0, 0, 3);
        wr(2, 32'h0, 32'h0, 0, 0, 1, 0, 1);
        fill(8'h00);
        send(80, 1, 3, "R11 last window word");
        send(67, 0, 1, "R11 window word incomplete");
        @(negedge clk); rx_vld = 1; rx_byte = 8'hFF;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); rx_vld = 1; rx_byte = 8'hEE; rx_sof = (i == 0); rx_eof = 0;
        end
        send(70, 1, 3, "R11 restart after stray and open frame");

        // R8: back-to-back single-byte frames
        @(negedge clk); rx_vld = 1; rx_sof = 1; rx_eof = 1; rx_byte = 8'h00;
        @(negedge clk);
        check(vd_vld === 1'b1 && vd_pass === 1'b0 && vd_chan === 4'd1, "R8 first of pair",
              {vd_vld, vd_pass, vd_chan}, {1'b1, 1'b0, 4'd1});
        @(negedge clk); rx_vld = 0; rx_sof = 0; rx_eof = 0;
        check(vd_vld === 1'b1, "R8 second of pair", int'(vd_vld), 1);
        @(negedge clk);
        check(vd_vld === 1'b0, "R8 strobe drops", int'(vd_vld), 0);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule